// File: doc/BRIEF.md
# Flagless Multi-Cycle RISC Core

A compact 32-bit load/store processor core. It runs one instruction at a time through seven fixed phases, each of which lasts exactly one clock. A new instruction is started only once the previous one has written back. The core has no condition flags. A compare writes a small bitmask into an ordinary general register, and a conditional branch names the register whose bits it tests. A subroutine call uses a save-PC instruction to put a return address into a register, then an unconditional branch. The return is an indirect branch through that register.

The core has a single synchronous memory port. Read data appears on `mem_rdata` in the clock after the read request. The same port serves the boot image at address 0, data RAM and memory-mapped I/O. Because the core never stalls, every device on the port must answer within that one-cycle slot. Instructions are 32 bits wide and come in three formats. Register r0 reads as zero.

Top module: `flagless_core`

## Requirements
- R1: After reset is released, the first cycle drives `mem_addr` = 0 with `mem_re` = 1. No `mem_we` is seen while reset is held.
- R2: Each instruction takes exactly seven cycles, in the order PC-out, fetch, decode, register read, execute, memory, writeback. Instruction fetches are seven cycles apart, and the port is idle except in the PC-out and memory phases.
- R3: Only load (opcode 0xB) and store (0xC) use the memory phase. The byte address is rs1 + sign-extended imm16, driven unchanged. This includes I/O such as address 0xF003, which returns the button word. Load data arriving in the next cycle is written to rd. A store drives the rd register as `mem_wdata` with `mem_we` = 1.
- R4: The opcode is in bits 31:28 and the destination in bits 27:24. Register form ops use rs1 in 23:20 and rs2 in 19:16: 0x0 add, 0x1 subtract, 0x2 and, 0x3 or, 0x4 xor. Immediate form ops use rs1 in 23:20 and imm16 in 15:0, sign-extended: 0x5 add, 0x6 and, 0x7 or, 0x8 shift left and 0x9 shift right logical (by imm[4:0]).
- R5: Compare (0xA, register form) writes a mask to rd. Bit 0 is set when the operands are equal, bit 1 when rs1 < rs2 signed, and bit 2 when rs1 < rs2 unsigned. All other bits are 0.
- R6: Branch (0xE) holds a test register in 27:24, a mode in 23:20 and a signed 20-bit word offset in 19:0. The target is the branch's own PC + 4×offset. With mode[1:0] = 0 the branch is always taken. Otherwise it is taken when bit (mode[1:0]−1) of the test register, XOR mode[2], is 1. When not taken, the PC advances by 4.
- R7: Save-PC (0xD, immediate form) writes its own PC + imm16 to rd. A branch with mode[3] = 1 jumps to the value of the test register, which gives a subroutine return.
- R8: r0 reads as 0, and writes to it have no effect.
- R9: Opcode 0xF changes no register and no memory, and only advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address for a fetch, load or store |
| mem_re | output | 1 | Read request; data is expected on `mem_rdata` next cycle |
| mem_we | output | 1 | Store strobe |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data returned one cycle after `mem_re` |

## Verification
The bench goes after the compare mask on a negative-versus-positive pair, where the signed and unsigned orderings disagree. A core that reused one comparison for both would write 6 or 0 instead of 2 and 4. It takes both senses of a conditional branch, including the inverted mode, and makes a call and return through save-PC. A wrong PC base or offset scaling would send the fetch address off the expected path on the very next PC-out cycle. It also writes to r0, loads from the odd I/O address built with a shift, and executes an undefined opcode with non-zero fields. These catch a core that lets r0 hold a value, that aligns or masks load addresses, or that decodes garbage fields of 0xF into an action.

// File: rtl/flagless_pkg.sv
package flagless_pkg;
  parameter int XLEN   = 32;
  parameter int NREG   = 16;
  parameter int RIDX   = $clog2(NREG);
  parameter int OPW    = 4;
  parameter int SHW    = $clog2(XLEN);
  parameter int IMMW   = 16;
  parameter int OFFW   = 20;

  typedef enum logic [2:0] {
    PH_PC, PH_FETCH, PH_DEC, PH_REG, PH_ALU, PH_MEM, PH_WB
  } phase_t;

  localparam logic [OPW-1:0] OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_AND  = 4'h2,
                             OP_OR   = 4'h3, OP_XOR  = 4'h4, OP_ADDI = 4'h5,
                             OP_ANDI = 4'h6, OP_ORI  = 4'h7, OP_SHL  = 4'h8,
                             OP_SHR  = 4'h9, OP_CMP  = 4'hA, OP_LD   = 4'hB,
                             OP_ST   = 4'hC, OP_SPC  = 4'hD, OP_BR   = 4'hE,
                             OP_UNDEF = 4'hF;

  typedef struct packed {
    logic [OPW-1:0]  op;
    logic [RIDX-1:0] rd;
    logic [RIDX-1:0] rs1;
    logic [RIDX-1:0] rs2;
    logic [3:0]      mode;
    logic [XLEN-1:0] imm;
    logic            use_imm;
    logic            wr_rd;
    logic            is_ld;
    logic            is_st;
    logic            is_br;
  } dec_t;

  function automatic logic [XLEN-1:0] cmp_word(logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    logic [XLEN-1:0] m;
    m    = '0;
    m[0] = (a == b);
    m[1] = ($signed(a) < $signed(b));
    m[2] = (a < b);
    return m;
  endfunction

  function automatic logic [XLEN-1:0] alu_word(logic [OPW-1:0] op, logic [XLEN-1:0] a,
                                               logic [XLEN-1:0] b, logic [XLEN-1:0] pc);
    case (op)
      OP_ADD, OP_ADDI, OP_LD, OP_ST: return a + b;
      OP_SUB:                        return a - b;
      OP_AND, OP_ANDI:               return a & b;
      OP_OR, OP_ORI:                 return a | b;
      OP_XOR:                        return a ^ b;
      OP_SHL:                        return a << b[SHW-1:0];
      OP_SHR:                        return a >> b[SHW-1:0];
      OP_CMP:                        return cmp_word(a, b);
      OP_SPC:                        return pc + b;
      default:                       return '0;
    endcase
  endfunction

  function automatic logic branch_taken(logic [3:0] mode, logic [XLEN-1:0] c);
    if (mode[3] || mode[1:0] == 2'd0) return 1'b1;
    return c[mode[1:0] - 2'd1] ^ mode[2];
  endfunction
endpackage

// File: rtl/fc_sequencer.sv
module fc_sequencer
  import flagless_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase <= PH_PC;
    else if (phase == PH_WB)  phase <= PH_PC;
    else                      phase <= phase_t'(phase + 3'd1);
  end
endmodule

// File: rtl/fc_decoder.sv
module fc_decoder
  import flagless_pkg::*;
(
  input  logic [XLEN-1:0] ir,
  output dec_t            d
);
  logic [OPW-1:0] op;
  assign op = ir[31:28];

  always_comb begin
    d.op      = op;
    d.rd      = ir[27:24];
    d.rs1     = ir[23:20];
    d.rs2     = ir[19:16];
    d.mode    = ir[23:20];
    d.is_ld   = (op == OP_LD);
    d.is_st   = (op == OP_ST);
    d.is_br   = (op == OP_BR);
    d.use_imm = (op >= OP_ADDI && op <= OP_SHR) || op == OP_LD || op == OP_ST || op == OP_SPC;
    d.wr_rd   = !(op == OP_ST || op == OP_BR || op == OP_UNDEF);
    if (op == OP_BR) d.imm = {{(XLEN-OFFW-2){ir[OFFW-1]}}, ir[OFFW-1:0], 2'b00};
    else             d.imm = {{(XLEN-IMMW){ir[IMMW-1]}}, ir[IMMW-1:0]};
  end
endmodule

// File: rtl/fc_regfile.sv
module fc_regfile
  import flagless_pkg::*;
#(
  parameter int NRD = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][RIDX-1:0]  raddr,
  output logic [NRD-1:0][XLEN-1:0]  rdata,
  input  logic                      we,
  input  logic [RIDX-1:0]           waddr,
  input  logic [XLEN-1:0]           wdata
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
  end
endmodule

// File: rtl/fc_alu.sv
module fc_alu
  import flagless_pkg::*;
(
  input  logic [OPW-1:0]  op,
  input  logic [3:0]      mode,
  input  logic            is_br,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] c,
  input  logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] res,
  output logic            take,
  output logic [XLEN-1:0] target
);
  assign res    = alu_word(op, a, b, pc);
  assign take   = is_br && branch_taken(mode, c);
  assign target = mode[3] ? c : pc + imm;
endmodule

// File: rtl/flagless_core.sv
module flagless_core
  import flagless_pkg::*;
#(
  parameter logic [31:0] BOOT_ADDR = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] mem_addr,
  output logic        mem_re,
  output logic        mem_we,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam int NRD = 3;

  phase_t          phase;
  logic [XLEN-1:0] pc_q, ir_q, opa, opb, opd, res_q, tgt_q;
  logic            take_q;
  dec_t            dec_w, dq;

  logic [NRD-1:0][RIDX-1:0] rf_ra;
  logic [NRD-1:0][XLEN-1:0] rf_rd;
  logic [XLEN-1:0]          alu_res, alu_tgt;
  logic                     alu_take;

  logic            wb_en;
  logic [XLEN-1:0] wb_data;
  logic [OPW-1:0]  cur_op;
  logic [RIDX-1:0] cur_rs1;

  fc_sequencer u_seq (.clk(clk), .rst_n(rst_n), .phase(phase));

  fc_decoder u_dec (.ir(ir_q), .d(dec_w));

  assign rf_ra   = {dq.rd, dq.rs2, dq.rs1};
  assign wb_en   = (phase == PH_WB) && dq.wr_rd;
  assign wb_data = dq.is_ld ? mem_rdata : res_q;
  assign cur_op  = dq.op;
  assign cur_rs1 = dq.rs1;

  fc_regfile #(.NRD(NRD)) u_rf (
    .clk(clk), .rst_n(rst_n), .raddr(rf_ra), .rdata(rf_rd),
    .we(wb_en), .waddr(dq.rd), .wdata(wb_data)
  );

  fc_alu u_alu (
    .op(dq.op), .mode(dq.mode), .is_br(dq.is_br), .imm(dq.imm),
    .a(opa), .b(opb), .c(opd), .pc(pc_q),
    .res(alu_res), .take(alu_take), .target(alu_tgt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= BOOT_ADDR;
      ir_q   <= '0;
      dq     <= '0;
      opa    <= '0;
      opb    <= '0;
      opd    <= '0;
      res_q  <= '0;
      tgt_q  <= '0;
      take_q <= 1'b0;
    end else begin
      case (phase)
        PH_FETCH: ir_q <= mem_rdata;
        PH_DEC:   dq   <= dec_w;
        PH_REG: begin
          opa <= rf_rd[0];
          opb <= dq.use_imm ? dq.imm : rf_rd[1];
          opd <= rf_rd[2];
        end
        PH_ALU: begin
          res_q  <= alu_res;
          take_q <= alu_take;
          tgt_q  <= alu_tgt;
        end
        PH_WB:   pc_q <= take_q ? tgt_q : pc_q + 32'd4;
        default: ;
      endcase
    end
  end

  assign mem_addr  = (phase == PH_MEM) ? res_q : pc_q;
  assign mem_re    = (phase == PH_PC) || (phase == PH_MEM && dq.is_ld);
  assign mem_we    = (phase == PH_MEM) && dq.is_st;
  assign mem_wdata = opd;
endmodule

// File: rtl/fc_checker.sv
module fc_checker
  import flagless_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      phase,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] mem_addr,
  input logic            mem_re,
  input logic            mem_we,
  input logic [OPW-1:0]  cur_op,
  input logic [RIDX-1:0] cur_rs1,
  input logic [XLEN-1:0] opa,
  input logic            wb_en
);
  localparam logic [2:0] P_PC  = 3'd0;
  localparam logic [2:0] P_ALU = 3'd4;
  localparam logic [2:0] P_MEM = 3'd5;
  localparam logic [2:0] P_WB  = 3'd6;

  assert_fetch_at_pc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_PC) |-> (mem_re && !mem_we && mem_addr == pc));

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != P_WB) |=> (phase == $past(phase) + 3'd1));

  assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_WB) |=> (phase == P_PC));

  assert_bus_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re || mem_we) |-> (phase == P_PC || phase == P_MEM));

  assert_store_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cur_op == OP_ST));

  assert_load_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_MEM && cur_op == OP_LD) |-> mem_re);

  assert_store_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_WB && cur_op == OP_ST) |-> !wb_en);

  assert_r0_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_ALU && cur_rs1 == '0) |-> (opa == '0));

  assert_undef_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_WB && cur_op == OP_UNDEF) |=> (pc == $past(pc) + 32'd4));

  assert_undef_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_WB && cur_op == OP_UNDEF) |-> !wb_en);
endmodule

bind flagless_core fc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .pc(pc_q), .mem_addr(mem_addr),
  .mem_re(mem_re), .mem_we(mem_we), .cur_op(cur_op), .cur_rs1(cur_rs1),
  .opa(opa), .wb_en(wb_en)
);

// File: tb/flagless_core_tb.sv
module flagless_core_tb;
  localparam int NCYC = 700;
  localparam int WD   = 5000;
  localparam logic [31:0] BTN = 32'h0000_0002;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_re, mem_we;

  always #10 clk = ~clk;

  flagless_core u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [31:0] mem  [256];
  logic [31:0] mmem [256];
  logic [31:0] rg   [16];
  int checks = 0, fails = 0;
  bit done = 0;

  initial mem_rdata = '0;
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    if (mem_re) mem_rdata <= (mem_addr == 32'hF003) ? BTN : mem[mem_addr[9:2]];
  end

  function automatic logic [31:0] enc_r(int op, int rd, int a, int b);
    return {op[3:0], rd[3:0], a[3:0], b[3:0], 16'h0};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rd, int a, int imm);
    return {op[3:0], rd[3:0], a[3:0], 4'h0, imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_b(int cr, int mode, int off);
    return {4'hE, cr[3:0], mode[3:0], off[19:0]};
  endfunction

  task automatic put(int idx, logic [31:0] w);
    mem[idx] = w;
    mmem[idx] = w;
  endtask

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  // reference model state
  logic [31:0] mpc;
  bit          x_ld, x_st;
  logic [31:0] x_ea, x_wd;

  function automatic logic [31:0] bus_rd(logic [31:0] ea);
    if (ea == 32'hF003) return BTN;
    return mmem[ea[9:2]];
  endfunction

  task automatic put_reg(int r, logic [31:0] v);
    if (r != 0) rg[r] = v;
  endtask

  task automatic model_step();
    logic [31:0] ins, a, b, d, s16, npc, v;
    int op, rd, mode;
    ins = mmem[mpc[9:2]];
    op = ins[31:28]; rd = ins[27:24];
    a = rg[ins[23:20]]; b = rg[ins[19:16]]; d = rg[rd];
    s16 = {{16{ins[15]}}, ins[15:0]};
    npc = mpc + 4; x_ld = 0; x_st = 0;
    case (op)
      0: put_reg(rd, a + b);
      1: put_reg(rd, a - b);
      2: put_reg(rd, a & b);
      3: put_reg(rd, a | b);
      4: put_reg(rd, a ^ b);
      5: put_reg(rd, a + s16);
      6: put_reg(rd, a & s16);
      7: put_reg(rd, a | s16);
      8: put_reg(rd, a << s16[4:0]);
      9: put_reg(rd, a >> s16[4:0]);
      10: begin
        v = 0;
        if (a == b) v = v | 1;
        if ($signed(a) < $signed(b)) v = v | 2;
        if (a < b) v = v | 4;
        put_reg(rd, v);
      end
      11: begin x_ld = 1; x_ea = a + s16; put_reg(rd, bus_rd(x_ea)); end
      12: begin x_st = 1; x_ea = a + s16; x_wd = d; mmem[x_ea[9:2]] = d; end
      13: put_reg(rd, mpc + s16);
      14: begin
        mode = ins[23:20];
        if (mode[3]) npc = d;
        else if (mode[1:0] == 0 || (d[mode[1:0]-1] != mode[2]))
          npc = mpc + ({{12{ins[19]}}, ins[19:0]} * 4);
      end
      default: ;
    endcase
    mpc = npc;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", WD, NCYC);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] last_fetch;
    int k;
    for (int i = 0; i < 256; i++) begin mem[i] = '0; mmem[i] = '0; end
    for (int i = 0; i < 16; i++) rg[i] = '0;
    put(0,  enc_i(5, 1, 0, 5));
    put(1,  enc_i(5, 2, 0, -3));
    put(2,  enc_r(0, 3, 1, 2));
    put(3,  enc_r(1, 4, 2, 1));
    put(4,  enc_i(12, 3, 0, 'h200));
    put(5,  enc_i(12, 4, 0, 'h204));
    put(6,  enc_r(10, 5, 2, 1));
    put(7,  enc_i(12, 5, 0, 'h208));
    put(8,  enc_r(10, 6, 1, 1));
    put(9,  enc_r(10, 7, 1, 2));
    put(10, enc_i(12, 6, 0, 'h20C));
    put(11, enc_i(12, 7, 0, 'h210));
    put(12, enc_b(5, 1, 2));
    put(13, enc_i(5, 8, 0, 'h11));
    put(14, enc_b(6, 1, 2));
    put(15, enc_i(5, 8, 0, 'h22));
    put(16, enc_i(12, 8, 0, 'h214));
    put(17, enc_i(13, 9, 0, 12));
    put(18, enc_b(0, 0, 12));
    put(20, enc_i(12, 10, 0, 'h218));
    put(21, enc_i(5, 12, 0, 'h0F00));
    put(22, enc_i(8, 12, 12, 4));
    put(23, enc_i(11, 11, 12, 3));
    put(24, enc_i(6, 13, 11, 2));
    put(25, enc_i(12, 13, 0, 'h21C));
    put(26, enc_i(5, 0, 0, 7));
    put(27, enc_i(12, 0, 0, 'h220));
    put(28, 32'hF123_4567);
    put(29, enc_b(0, 0, 0));
    put(30, enc_i(5, 10, 0, 'h33));
    put(31, enc_r(4, 10, 10, 1));
    put(32, enc_i(9, 14, 4, 28));
    put(33, enc_r(2, 15, 4, 14));
    put(34, enc_r(3, 15, 15, 1));
    put(35, enc_i(12, 15, 0, 'h224));
    put(36, enc_b(5, 5, 2));
    put(37, enc_i(5, 10, 0, 'h99));
    put(38, enc_b(9, 8, 0));

    rst_n = 1'b0;
    mpc = 32'h0;
    last_fetch = '1;
    repeat (3) @(negedge clk);
    #1;
    check(mem_we == 1'b0, "R1", "store strobe in reset", {31'b0, mem_we}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    k = 0;
    for (int c = 0; c < NCYC; c++) begin
      if (k == 0) begin
        check(mem_re && !mem_we, (c == 0) ? "R1" : "R2", "fetch strobes",
              {30'b0, mem_re, mem_we}, 32'h2);
        check(mem_addr == mpc, (c == 0) ? "R1" : "R2", "fetch address", mem_addr, mpc);
        last_fetch = mem_addr;
        model_step();
      end else if (k == 5) begin
        check(mem_re == x_ld && mem_we == x_st, "R3", "memory slot strobes",
              {30'b0, mem_re, mem_we}, {30'b0, x_ld, x_st});
        if (x_ld || x_st) check(mem_addr == x_ea, "R3", "data address", mem_addr, x_ea);
        if (x_st) check(mem_wdata == x_wd, "R3", "store data", mem_wdata, x_wd);
      end else begin
        check(!mem_re && !mem_we, "R2", "idle phase strobes",
              {30'b0, mem_re, mem_we}, 32'h0);
      end
      k = (k == 6) ? 0 : k + 1;
      @(negedge clk);
      #1;
    end

    check(mem[128] == 32'h2,         "R4", "add result",          mem[128], 32'h2);
    check(mem[129] == 32'hFFFF_FFF8, "R4", "sub result",          mem[129], 32'hFFFF_FFF8);
    check(mem[130] == 32'h2,         "R5", "cmp neg vs pos",      mem[130], 32'h2);
    check(mem[131] == 32'h1,         "R5", "cmp equal",           mem[131], 32'h1);
    check(mem[132] == 32'h4,         "R5", "cmp pos vs neg",      mem[132], 32'h4);
    check(mem[133] == 32'h11,        "R6", "branch skip/take",    mem[133], 32'h11);
    check(mem[134] == 32'h36,        "R7", "call and return",     mem[134], 32'h36);
    check(mem[135] == 32'h2,         "R3", "button load",         mem[135], 32'h2);
    check(mem[136] == 32'h0,         "R8", "r0 after write",      mem[136], 32'h0);
    check(mem[137] == 32'hD,         "R4", "shift/and/or chain",  mem[137], 32'hD);
    check(last_fetch == 32'd116,     "R9", "pc past undefined op", last_fetch, 32'd116);
    done = 1;
    summary();
    $finish;
  end
endmodule